// File: doc/BRIEF.md
# Address-Masked GPIO Port

This block is an eight-pin general-purpose I/O port on a simple byte-wide register bus with single-cycle read and write strobes. It holds a direction byte and an output value byte. It drives the pad output values and the per-pin output enables. It samples the pad inputs through a two-stage synchronizer.

Pin data is not held at a single address. It is reached through a window of 256 word-aligned locations, and the address of each access selects the pins it touches. Address bit n+2 enables pin n. A write through the window changes only the enabled pins, so software can set or clear one pin in a single store, with no read-modify-write and no lock. A read through the window returns the current pin levels for the enabled pins and zero for all the others.

Read data is registered. It appears after the clock edge that samples the read strobe and holds until the next read.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset the direction byte and the output value byte are zero. Every pin is an input, `pad_oe` and `pad_out` are 0x00, and `rdata` is 0x00.
- R2: An access whose address has bit 10 clear and bits [1:0] clear is a window access. Its pin mask is address bits [9:2], and address bit n+2 selects pin n.
- R3: A window write changes only the stored output bits that are selected by the mask. Every unselected bit keeps its value.
- R4: A window read places, on the edge that samples `rd_en`, the level of each selected pin in `rdata` and 0 in every unselected bit. The value is held until the next read.
- R5: The direction byte is at address 0x400 and reads back from there. A 1 in bit n makes pin n an output. `pad_oe` follows the direction byte from the edge after the write.
- R6: A window write leaves the stored output bit of every pin that is an input unchanged, even when its mask bit is set.
- R7: `pad_out` always presents the stored output value byte, whatever the direction.
- R8: For an input pin, a read returns `pad_in` as it was two clock edges before the read's edge, through two synchronizer flops. For an output pin, a read returns the stored output value.
- R9: Any address that is neither a window location nor 0x400 reads as 0x00, and a write to it changes nothing.
- R10: When a read and a write hit the same address in one cycle, `rdata` carries the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| addr | input | 11 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pad_in | input | 8 | Pad input levels (asynchronous) |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables, 1 means drive |

## Verification
Window writes are tried with a full mask, a single-bit mask and random masks. This separates a mask that is decoded from the wrong address bits from a write that ignores the mask altogether. The same writes are issued with the pins first as inputs and then as outputs, which exposes a store that ignores direction.

A pad change is followed by three back-to-back reads, to pin down the two-flop latency exactly. Accesses at 0x404 and at a window address that is not word-aligned show whether decode leaks outside the mapped set. A long random mix of reads, writes and pad changes is compared every clock against a behavioural model.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;
  // Kind of register selected by a bus address
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_DATA = 2'd1,
    ACC_DIR  = 2'd2
  } acc_kind_t;
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_mask_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int PINS     = 8,
  parameter int MASK_LSB = 2,
  parameter logic [ADDR_W-1:0] DIR_OFS = 11'h400
) (
  input  logic [ADDR_W-1:0] addr,
  output acc_kind_t         kind,
  output logic [PINS-1:0]   mask
);
  localparam int MASK_MSB = MASK_LSB + PINS - 1;

  // Window: everything above the mask field is zero and the address is word aligned
  function automatic logic window_hit(input logic [ADDR_W-1:0] a);
    return (a[ADDR_W-1:MASK_MSB+1] == '0) && (a[MASK_LSB-1:0] == '0);
  endfunction

  function automatic logic [PINS-1:0] window_mask(input logic [ADDR_W-1:0] a);
    return a[MASK_MSB:MASK_LSB];
  endfunction

  always_comb begin
    mask = window_mask(addr);
    if (window_hit(addr))      kind = ACC_DATA;
    else if (addr == DIR_OFS)  kind = ACC_DIR;
    else                       kind = ACC_NONE;
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int PINS   = 8,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] din,
  output logic [PINS-1:0] dout
);
  logic [PINS-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= din;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[k] <= '0;
      else        stage_q[k] <= stage_q[k-1];
    end

    // Each stage takes the previous stage's value one edge later
    assert_sync_shift_R8: assert property (@(posedge clk) disable iff (!rst_n)
      stage_q[k] == $past(stage_q[k-1]));
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int PINS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_data_evt,
  input  logic            wr_dir_evt,
  input  logic [PINS-1:0] wmask,
  input  logic [PINS-1:0] wdata,
  output logic [PINS-1:0] dir_q,
  output logic [PINS-1:0] out_q
);
  // Only bits that are both selected and outputs take the new value
  function automatic logic [PINS-1:0] merge_out(
    input logic [PINS-1:0] old_v, input logic [PINS-1:0] new_v,
    input logic [PINS-1:0] sel,   input logic [PINS-1:0] dir_v);
    logic [PINS-1:0] en;
    en = sel & dir_v;
    return (old_v & ~en) | (new_v & en);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
    end else begin
      if (wr_dir_evt)  dir_q <= wdata;
      if (wr_data_evt) out_q <= merge_out(out_q, wdata, wmask, dir_q);
    end
  end

  assert_unmasked_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data_evt |=> ((out_q ^ $past(out_q)) & ~$past(wmask)) == '0);

  assert_input_pin_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data_evt |=> ((out_q ^ $past(out_q)) & ~$past(dir_q)) == '0);

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_data_evt || wr_dir_evt) |=> ($stable(out_q) && $stable(dir_q)));
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_mask_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int PINS        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PINS-1:0]   wdata,
  output logic [PINS-1:0]   rdata,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe
);
  localparam logic [ADDR_W-1:0] DIR_OFS = ADDR_W'(11'h400);

  acc_kind_t       acc_kind;
  logic [PINS-1:0] acc_mask;
  logic [PINS-1:0] dir_q, out_q, pad_sync;
  logic [PINS-1:0] pin_view;
  logic            wr_data_evt, wr_dir_evt;
  logic            rd_data_evt, rd_dir_evt, rd_none_evt;

  gpio_addr_decode #(.ADDR_W(ADDR_W), .PINS(PINS), .MASK_LSB(2), .DIR_OFS(DIR_OFS)) u_dec (
    .addr (addr),
    .kind (acc_kind),
    .mask (acc_mask)
  );

  assign wr_data_evt = wr_en && (acc_kind == ACC_DATA);
  assign wr_dir_evt  = wr_en && (acc_kind == ACC_DIR);
  assign rd_data_evt = rd_en && (acc_kind == ACC_DATA);
  assign rd_dir_evt  = rd_en && (acc_kind == ACC_DIR);
  assign rd_none_evt = rd_en && (acc_kind == ACC_NONE);

  gpio_port_regs #(.PINS(PINS)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_data_evt (wr_data_evt),
    .wr_dir_evt  (wr_dir_evt),
    .wmask       (acc_mask),
    .wdata       (wdata),
    .dir_q       (dir_q),
    .out_q       (out_q)
  );

  gpio_in_sync #(.PINS(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (pad_in),
    .dout  (pad_sync)
  );

  // Output pins show the driven value, input pins show the synchronized pad
  function automatic logic [PINS-1:0] pin_levels(
    input logic [PINS-1:0] dir_v, input logic [PINS-1:0] out_v,
    input logic [PINS-1:0] in_v);
    return (dir_v & out_v) | (~dir_v & in_v);
  endfunction

  assign pin_view = pin_levels(dir_q, out_q, pad_sync);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           rdata <= '0;
    else if (rd_data_evt) rdata <= pin_view & acc_mask;
    else if (rd_dir_evt)  rdata <= dir_q;
    else if (rd_none_evt) rdata <= '0;
  end

  assign pad_out = out_q;
  assign pad_oe  = dir_q;

  assert_read_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_evt |=> (rdata & ~$past(acc_mask)) == '0);

  assert_dir_to_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir_evt |=> pad_oe == $past(wdata));

  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_none_evt |=> rdata == '0);

  assert_rdata_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

// File: tb/gpio_mask_port_test.sv
module gpio_mask_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [10:0] addr = '0;
  logic [7:0]  wdata = '0, pad_in = '0;
  logic [7:0]  rdata, pad_out, pad_oe;

  int errors = 0, checks = 0;
  bit done = 0;

  gpio_mask_port uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  always #2ns clk = ~clk;

  // Behavioural reference: plain variables and a queue for the pad pipeline
  logic [7:0] m_dir, m_out, m_rd;
  logic [7:0] pad_hist[$];

  initial begin
    m_dir = 0; m_out = 0; m_rd = 0;
    pad_hist = {8'h00, 8'h00};
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_dir = 0; m_out = 0; m_rd = 0;
      pad_hist = {8'h00, 8'h00};
    end else begin
      logic [7:0] seen, msk;
      logic is_win, is_dir;
      int old_dir;
      seen = 0;
      is_win = (addr[10] == 1'b0) && (addr[1:0] == 2'b00);
      is_dir = (addr == 11'h400);
      msk = addr[9:2];
      old_dir = m_dir;
      for (int n = 0; n < 8; n++)
        seen[n] = m_dir[n] ? m_out[n] : pad_hist[0][n];
      if (rd_en) m_rd = is_win ? (seen & msk) : (is_dir ? m_dir : 8'h00);
      if (wr_en && is_dir) m_dir = wdata;
      if (wr_en && is_win)
        for (int n = 0; n < 8; n++)
          if (msk[n] && old_dir[n]) m_out[n] = wdata[n];
      void'(pad_hist.pop_front());
      pad_hist.push_back(pad_in);
    end
  end

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) if (rst_n && !done) begin
    check("R5 pad_oe", pad_oe, m_dir);
    check("R7 pad_out", pad_out, m_out);
    check("R4 rdata", rdata, m_rd);
  end

  // Tasks are entered at a falling edge and return at the next one
  task automatic wr(logic [10:0] a, logic [7:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(logic [10:0] a, output logic [7:0] d);
    rd_en = 1; addr = a;
    @(negedge clk);
    rd_en = 0;
    d = rdata;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(4ns * 100000);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 pad_oe", pad_oe, 8'h00);
    check("R1 pad_out", pad_out, 8'h00);
    check("R1 rdata", rdata, 8'h00);
    rd(11'h400, v); check("R1 dir", v, 8'h00);
    // R5 direction
    wr(11'h400, 8'h0F);
    check("R5 oe", pad_oe, 8'h0F);
    rd(11'h400, v); check("R5 readback", v, 8'h0F);
    // R3 full mask, R6 upper pins are inputs
    wr(11'h3FC, 8'hFF);
    check("R3 R6 full mask", pad_out, 8'h0F);
    // R2 single bit mask: address 0x008 selects pin 1 only
    wr(11'h008, 8'h00);
    check("R2 pin1 clear", pad_out, 8'h0D);
    wr(11'h004, 8'h00);
    check("R2 pin0 clear", pad_out, 8'h0C);
    wr(11'h004, 8'hFF);
    check("R3 pin0 set", pad_out, 8'h0D);
    // R6 inputs kept stored value when turned into outputs
    wr(11'h400, 8'hFF);
    check("R6 upper stay", pad_out, 8'h0D);
    wr(11'h400, 8'h0F);
    // R8 input path and latency
    pad_in = 8'hA0;
    repeat (3) @(negedge clk);
    rd(11'h3FC, v); check("R8 R4 mixed read", v, 8'hAD);
    rd(11'h0C0, v); check("R4 masked read", v, 8'h20);
    pad_in = 8'h50;
    rd(11'h3C0, v); check("R8 latency 1", v, 8'hA0);
    rd(11'h3C0, v); check("R8 latency 2", v, 8'hA0);
    rd(11'h3C0, v); check("R8 latency 3", v, 8'h50);
    // R9 unmapped
    wr(11'h404, 8'hFF);
    rd(11'h400, v); check("R9 dir untouched", v, 8'h0F);
    rd(11'h404, v); check("R9 read zero", v, 8'h00);
    rd(11'h3FD, v); check("R9 misaligned read", v, 8'h00);
    wr(11'h3FD, 8'h00);
    check("R9 misaligned write", pad_out, 8'h0D);
    // R10 read and write together
    wr_en = 1; rd_en = 1; addr = 11'h400; wdata = 8'h33;
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    check("R10 old value", rdata, 8'h0F);
    check("R10 new dir", pad_oe, 8'h33);
    // Random mix, compared every clock by the model
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom_range(0, 3);
      if ($urandom_range(0, 3) == 0) pad_in = 8'($urandom);
      case (op)
        0: wr(11'($urandom_range(0, 255) << 2), 8'($urandom));
        1: rd(11'($urandom_range(0, 255) << 2), v);
        2: wr(11'h400, 8'($urandom));
        default: begin
          wr_en = $urandom_range(0, 1) == 1; rd_en = 1;
          addr = 11'($urandom); wdata = 8'($urandom);
          @(negedge clk);
          wr_en = 0; rd_en = 0;
        end
      endcase
    end
    finish_run();
  end
endmodule